// File: doc/BRIEF.md
# ECC Error Logging and Interrupt Unit

This block sits next to the single-error-correct, double-error-detect checker of a memory controller. Every access the checker inspects arrives here as one cycle of indications: a valid strobe, a single-bit flag, a double-bit flag, the syndrome code, the access address and data, and whether the access was a plain read or the write half of a read-modify-write. The block applies a control word to these indications. It decides in the same cycle whether the read or write response carries an error flag, so that the requesting core can raise an exception.

Qualifying errors set a two-bit pending vector. Bit 0 is set by any error and bit 1 only by double-bit errors. Software clears each bit by writing 1 to it, and a mask decides which pending bits drive a level-sensitive interrupt line. A log holds the syndrome, address and data of the first qualifying error. It stays frozen while the pending bit that governs it is set. A control bit chooses whether logging follows any error or only double-bit errors. Nothing is reported, flagged or logged unless the controller runs its 64-bit data mode.

The registers are reached through a plain word-wide port: a write strobe, a word index, write data, and read data that reflects the addressed register in the same cycle.

Top module: `ecc_err_log`

## Requirements
- R1: With control bit 0 (enable) clear, no response flag is raised, no pending bit is set and the log is not written.
- R2: With `wide_mode` low, error indications have no effect at all: no response flag, no pending bit, no log write.
- R3: `rd_resp_err` is high in the same cycle as an enabled double-bit error on a read access when control bit 1 is set, and low otherwise.
- R4: `wr_resp_err` is high in the same cycle as an enabled double-bit error on a read-modify-write access when control bit 2 is set, and low otherwise.
- R5: An enabled error sets pending bit 0 at the next clock edge. An enabled double-bit error also sets pending bit 1. A single-bit error leaves pending bit 1 unchanged.
- R6: Writing to word 2 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R7: `irq` equals the OR of the pending bits ANDed with the mask held in word 1 (bits 1:0).
- R8: With control bit 3 clear, an enabled single- or double-bit error that finds pending bit 0 clear is captured. The syndrome appears in word 3, the address in word 4, and the data in words 5 (low) and 6 (high).
- R9: With control bit 3 set, only double-bit errors are captured, and single-bit errors leave the log unchanged.
- R10: The log keeps its contents while its governing pending bit is set: bit 0 when control bit 3 is 0, bit 1 when it is 1.
- R11: When an error arrives in the same cycle as a write-one-to-clear of a pending bit, the pending bit ends up set. If the cleared bit governs the log, the new error is captured.
- R12: After reset every register reads 0. Words 0 (control, bits 3:0) and 1 (mask, bits 1:0) read back what was written, and unused word indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | Controller runs 64-bit data mode |
| err_valid | input | 1 | Checker result valid this cycle |
| err_single | input | 1 | Corrected single-bit error |
| err_double | input | 1 | Uncorrectable double-bit error |
| err_is_write | input | 1 | Access is the write half of a read-modify-write |
| err_code | input | CODE_W | Syndrome code |
| err_addr | input | ADDR_W | Access address |
| err_data | input | DATA_W | Access data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Addressed register contents |
| rd_resp_err | output | 1 | Error flag on the read response |
| wr_resp_err | output | 1 | Error flag on the write response |
| irq | output | 1 | Level interrupt |

## Verification
A new error and a software write-one-to-clear of the same pending bit can land in the same clock edge. This race decides both the pending bit and whether the frozen log reopens. The bench provokes it on purpose: it pulses a double-bit error while writing 1 to the governing bit in double-only mode. It then reads the pending word and the address word back and expects the bit to be set and the new address to be logged. The behavioural reference model applies the same clear-then-set rule in every cycle of a long random phase, where reads, clears and errors collide freely.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

   // register word indices
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_MASK  = 1;
   localparam int unsigned REG_VEC   = 2;
   localparam int unsigned REG_CODE  = 3;
   localparam int unsigned REG_ADDR  = 4;
   localparam int unsigned REG_DATA0 = 5;

   localparam int unsigned NVEC = 2;

   // control word: bit 0 enable, bit 1 read flag, bit 2 write flag, bit 3 double-only log
   typedef struct packed {
      logic dbl_only;
      logic wr_flag;
      logic rd_flag;
      logic en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ecc_qualify.sv
module ecc_qualify
   import ecc_log_pkg::*;
(
   input  logic  wide_mode,
   input  ctrl_t ctrl,
   input  logic  err_valid,
   input  logic  err_single,
   input  logic  err_double,
   input  logic  err_is_write,
   output logic  hit_any,
   output logic  hit_dbl,
   output logic  rd_flag,
   output logic  wr_flag
);

   logic active;

   always_comb begin
      active  = err_valid & wide_mode & ctrl.en;
      hit_dbl = active & err_double;
      hit_any = active & (err_single | err_double);
      rd_flag = hit_dbl & ctrl.rd_flag & ~err_is_write;
      wr_flag = hit_dbl & ctrl.wr_flag &  err_is_write;
   end

endmodule

// File: rtl/ecc_irq_vector.sv
module ecc_irq_vector #(
   parameter int unsigned NBITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic [NBITS-1:0] clr_i,
   input  logic [NBITS-1:0] mask_i,
   output logic [NBITS-1:0] vec_q,
   output logic             irq
);

   generate
      if (NBITS < 1) begin : g_bad
         $error("ecc_irq_vector: NBITS must be at least 1");
      end
   endgenerate

   // one pending flop per bit; a set in the clearing cycle wins
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec_q[b] <= 1'b0;
         else if (set_i[b])
            vec_q[b] <= 1'b1;
         else if (clr_i[b])
            vec_q[b] <= 1'b0;
      end
   end

   assign irq = |(vec_q & mask_i);

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              frozen,
   input  logic [CODE_W-1:0] code_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   logic take;
   assign take = trig & ~frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (take) begin
         code_q <= code_i;
         addr_q <= addr_i;
         data_q <= data_i;
      end
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned RA_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic              err_valid,
   input  logic              err_single,
   input  logic              err_double,
   input  logic              err_is_write,
   input  logic [CODE_W-1:0] err_code,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [DATA_W-1:0] err_data,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              rd_resp_err,
   output logic              wr_resp_err,
   output logic              irq
);

   localparam int unsigned NWORDS = DATA_W / REG_W;
   localparam int unsigned NREG   = REG_DATA0 + NWORDS;

   localparam logic [RA_W-1:0] A_CTRL = RA_W'(REG_CTRL);
   localparam logic [RA_W-1:0] A_MASK = RA_W'(REG_MASK);
   localparam logic [RA_W-1:0] A_VEC  = RA_W'(REG_VEC);
   localparam logic [RA_W-1:0] A_CODE = RA_W'(REG_CODE);
   localparam logic [RA_W-1:0] A_ADDR = RA_W'(REG_ADDR);

   generate
      if (DATA_W % REG_W != 0) begin : g_bad_data
         $error("ecc_err_log: DATA_W must be a multiple of REG_W");
      end
      if (CODE_W > REG_W || ADDR_W > REG_W) begin : g_bad_field
         $error("ecc_err_log: CODE_W and ADDR_W must fit a register word");
      end
      if ((1 << RA_W) < NREG) begin : g_bad_ra
         $error("ecc_err_log: RA_W too narrow for the register window");
      end
      if (REG_W < CTRL_W + 1) begin : g_bad_reg
         $error("ecc_err_log: REG_W too narrow");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [NVEC-1:0]   mask_q;
   logic [NVEC-1:0]   vec_q;
   logic [NVEC-1:0]   vec_clr;
   logic              hit_any, hit_dbl;
   logic              log_trig, log_frozen;
   logic [CODE_W-1:0] log_code;
   logic [ADDR_W-1:0] log_addr;
   logic [DATA_W-1:0] log_data;
   logic              wdata_unused;

   assign wdata_unused = ^reg_wdata[REG_W-1:CTRL_W];

   // control and mask words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (reg_addr == A_MASK) mask_q <= reg_wdata[NVEC-1:0];
      end
   end

   assign vec_clr = (reg_wr && reg_addr == A_VEC) ? reg_wdata[NVEC-1:0] : '0;

   ecc_qualify u_qual (
      .wide_mode    (wide_mode),
      .ctrl         (ctrl_q),
      .err_valid    (err_valid),
      .err_single   (err_single),
      .err_double   (err_double),
      .err_is_write (err_is_write),
      .hit_any      (hit_any),
      .hit_dbl      (hit_dbl),
      .rd_flag      (rd_resp_err),
      .wr_flag      (wr_resp_err)
   );

   ecc_irq_vector #(.NBITS(NVEC)) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({hit_dbl, hit_any}),
      .clr_i  (vec_clr),
      .mask_i (mask_q),
      .vec_q  (vec_q),
      .irq    (irq)
   );

   // the governing pending bit, as it will stand after this cycle's clear
   always_comb begin
      if (ctrl_q.dbl_only) begin
         log_trig   = hit_dbl;
         log_frozen = vec_q[1] & ~vec_clr[1];
      end else begin
         log_trig   = hit_any;
         log_frozen = vec_q[0] & ~vec_clr[0];
      end
   end

   ecc_log_capture #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (log_trig),
      .frozen (log_frozen),
      .code_i (err_code),
      .addr_i (err_addr),
      .data_i (err_data),
      .code_q (log_code),
      .addr_q (log_addr),
      .data_q (log_data)
   );

   // read window
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = REG_W'(ctrl_q);
         A_MASK:  reg_rdata = REG_W'(mask_q);
         A_VEC:   reg_rdata = REG_W'(vec_q);
         A_CODE:  reg_rdata = REG_W'(log_code);
         A_ADDR:  reg_rdata = REG_W'(log_addr);
         default: reg_rdata = '0;
      endcase
      for (int w = 0; w < int'(NWORDS); w++) begin
         if (reg_addr == RA_W'(REG_DATA0 + w))
            reg_rdata = log_data[w*REG_W +: REG_W];
      end
   end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned RA_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_mode,
   input logic              err_valid,
   input logic              err_single,
   input logic              err_double,
   input logic              err_is_write,
   input logic              reg_wr,
   input logic [RA_W-1:0]   reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic              rd_resp_err,
   input logic              wr_resp_err,
   input logic              irq,
   input logic [3:0]        ctrl_bits,
   input logic [1:0]        mask_bits,
   input logic [1:0]        pend,
   input logic [CODE_W-1:0] lcode,
   input logic [ADDR_W-1:0] laddr
);

   localparam logic [RA_W-1:0] PEND_IDX = RA_W'(2);

   logic err_on, dbl_on, clr0, clr1;
   assign err_on = err_valid && wide_mode && ctrl_bits[0] && (err_single || err_double);
   assign dbl_on = err_valid && wide_mode && ctrl_bits[0] && err_double;
   assign clr0   = reg_wr && reg_addr == PEND_IDX && reg_wdata[0];
   assign clr1   = reg_wr && reg_addr == PEND_IDX && reg_wdata[1];

   assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_bits[0] |-> (!rd_resp_err && !wr_resp_err));

   assert_narrow_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> (!rd_resp_err && !wr_resp_err));

   assert_rd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_err |-> (err_valid && err_double && !err_is_write && ctrl_bits[1]));

   assert_wr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_resp_err |-> (err_valid && err_double && err_is_write && ctrl_bits[2]));

   assert_dbl_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_on |=> (pend == 2'b11));

   assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[0]) |-> $past(err_on));

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr0 && !err_on) |=> !pend[0]);

   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == 2'b00 || mask_bits == 2'b00) |-> !irq);

   assert_freeze_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_bits[3] && pend[0] && !clr0) |=> ($stable(laddr) && $stable(lcode)));

   assert_freeze_dbl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[3] && pend[1] && !clr1) |=> ($stable(laddr) && $stable(lcode)));

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr1 && dbl_on) |=> pend[1]);

endmodule

bind ecc_err_log ecc_err_log_chk #(
   .CODE_W (CODE_W),
   .ADDR_W (ADDR_W),
   .REG_W  (REG_W),
   .RA_W   (RA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wide_mode    (wide_mode),
   .err_valid    (err_valid),
   .err_single   (err_single),
   .err_double   (err_double),
   .err_is_write (err_is_write),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .rd_resp_err  (rd_resp_err),
   .wr_resp_err  (wr_resp_err),
   .irq          (irq),
   .ctrl_bits    (ctrl_q),
   .mask_bits    (mask_q),
   .pend         (vec_q),
   .lcode        (log_code),
   .laddr        (log_addr)
);

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b1;
   logic        err_valid = 1'b0, err_single = 1'b0, err_double = 1'b0, err_is_write = 1'b0;
   logic [7:0]  err_code = '0;
   logic [31:0] err_addr = '0;
   logic [63:0] err_data = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rd_resp_err, wr_resp_err, irq;

   int vectors = 0;
   int miscompares = 0;

   // reference state
   logic [3:0]  m_ctrl = '0;
   logic [1:0]  m_mask = '0, m_vec = '0;
   logic [7:0]  m_code = '0;
   logic [31:0] m_addr = '0;
   logic [63:0] m_data = '0;

   always #2 clk = ~clk;

   ecc_err_log uut (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
      .err_valid(err_valid), .err_single(err_single), .err_double(err_double),
      .err_is_write(err_is_write), .err_code(err_code), .err_addr(err_addr),
      .err_data(err_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_resp_err(rd_resp_err),
      .wr_resp_err(wr_resp_err), .irq(irq)
   );

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {28'd0, m_ctrl};
         3'd1: return {30'd0, m_mask};
         3'd2: return {30'd0, m_vec};
         3'd3: return {24'd0, m_code};
         3'd4: return m_addr;
         3'd5: return m_data[31:0];
         3'd6: return m_data[63:32];
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // one clock: inputs already driven; compare, then advance model
   task automatic step();
      logic act, s_any, s_dbl, fz, tr;
      logic [1:0] clr;
      #1;
      act = err_valid && wide_mode && m_ctrl[0];
      check("R3 rd_resp_err", rd_resp_err, act && err_double && m_ctrl[1] && !err_is_write);
      check("R4 wr_resp_err", wr_resp_err, act && err_double && m_ctrl[2] && err_is_write);
      check("R7 irq", irq, |(m_vec & m_mask));
      check("R12 reg_rdata", reg_rdata, m_read(reg_addr));
      @(posedge clk);
      s_any = act && (err_single || err_double);
      s_dbl = act && err_double;
      clr = (reg_wr && reg_addr == 3'd2) ? reg_wdata[1:0] : 2'b00;
      fz = m_ctrl[3] ? (m_vec[1] && !clr[1]) : (m_vec[0] && !clr[0]);
      tr = m_ctrl[3] ? s_dbl : s_any;
      if (tr && !fz) begin
         m_code = err_code; m_addr = err_addr; m_data = err_data;
      end
      m_vec = (m_vec & ~clr) | {s_dbl, s_any};
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata[3:0];
      if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata[1:0];
      @(negedge clk);
   endtask

   task automatic idle(input logic [2:0] ra);
      err_valid = 0; err_single = 0; err_double = 0; reg_wr = 0; reg_addr = ra;
      step();
   endtask

   task automatic wreg(input logic [2:0] ra, input logic [31:0] v);
      err_valid = 0; reg_wr = 1; reg_addr = ra; reg_wdata = v;
      step();
      reg_wr = 0;
   endtask

   task automatic inject(input logic sgl, input logic dbl, input logic wr,
                         input logic [31:0] a);
      err_valid = 1; err_single = sgl; err_double = dbl; err_is_write = wr;
      err_addr = a; err_code = a[7:0] ^ 8'h5A; err_data = {~a, a};
      reg_wr = 0;
      step();
      err_valid = 0; err_single = 0; err_double = 0;
   endtask

   // read a word in an idle cycle and compare against a fixed expectation
   task automatic expect_reg(input string tag, input logic [2:0] ra, input logic [31:0] v);
      err_valid = 0; reg_wr = 0; reg_addr = ra;
      #1;
      check(tag, reg_rdata, v);
      #0;
      idle(ra);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset values
      for (int a = 0; a < 8; a++) expect_reg("R12 reset value", 3'(a), 32'd0);
      // R1: disabled block ignores a double-bit error
      inject(0, 1, 0, 32'h1000);
      expect_reg("R1 pending stays clear", 3'd2, 32'd0);
      expect_reg("R1 log untouched", 3'd4, 32'd0);
      wreg(3'd0, 32'h7);
      wreg(3'd1, 32'h3);
      expect_reg("R12 control readback", 3'd0, 32'h7);
      expect_reg("R12 mask readback", 3'd1, 32'h3);
      // R2: narrow mode suppresses everything
      wide_mode = 0;
      inject(0, 1, 0, 32'h2000);
      wide_mode = 1;
      expect_reg("R2 pending stays clear", 3'd2, 32'd0);
      // R8: first single error logged
      inject(1, 0, 0, 32'hA100);
      expect_reg("R5 single sets bit0 only", 3'd2, 32'h1);
      expect_reg("R8 address logged", 3'd4, 32'hA100);
      expect_reg("R8 data high logged", 3'd6, ~32'hA100);
      // R10: frozen while bit0 set
      inject(1, 0, 0, 32'hA200);
      expect_reg("R10 log frozen", 3'd4, 32'hA100);
      // R3 / R4 via model
      inject(0, 1, 0, 32'hA300);
      inject(0, 1, 1, 32'hA400);
      expect_reg("R5 double sets both", 3'd2, 32'h3);
      // R6: writing zeros keeps bits; writing one clears
      wreg(3'd2, 32'h0);
      expect_reg("R6 zero write keeps", 3'd2, 32'h3);
      wreg(3'd2, 32'h1);
      expect_reg("R6 bit0 cleared", 3'd2, 32'h2);
      inject(1, 0, 0, 32'hA500);
      expect_reg("R8 log reopens", 3'd4, 32'hA500);
      // R7: mask gates interrupt
      wreg(3'd1, 32'h2);
      wreg(3'd2, 32'h3);
      inject(1, 0, 0, 32'hA600);
      #1; check("R7 masked single", irq, 1'b0); #0;
      idle(3'd2);
      // R9: double-only logging
      wreg(3'd0, 32'hF);
      wreg(3'd2, 32'h3);
      inject(1, 0, 0, 32'hB100);
      expect_reg("R9 single ignored by log", 3'd4, 32'hA600);
      inject(0, 1, 0, 32'hB200);
      expect_reg("R9 double logged", 3'd4, 32'hB200);
      inject(0, 1, 0, 32'hB300);
      expect_reg("R10 frozen on bit1", 3'd4, 32'hB200);
      // R11: clear and new error in the same cycle
      err_valid = 1; err_single = 0; err_double = 1; err_is_write = 0;
      err_addr = 32'hC100; err_code = 8'h33; err_data = 64'h1;
      reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h2;
      step();
      err_valid = 0; err_double = 0; reg_wr = 0;
      expect_reg("R11 set wins", 3'd2, 32'h3);
      expect_reg("R11 new error logged", 3'd4, 32'hC100);
      // random collisions
      for (int i = 0; i < 2000; i++) begin
         logic [3:0] r;
         r = 4'($urandom_range(0, 15));
         wide_mode    = ($urandom_range(0, 9) != 0);
         err_valid    = r[0];
         err_single   = r[1];
         err_double   = r[2] & r[3];
         err_is_write = 1'($urandom_range(0, 1));
         err_addr     = $urandom;
         err_code     = 8'($urandom);
         err_data     = {$urandom, $urandom};
         reg_wr       = ($urandom_range(0, 3) == 0);
         reg_addr     = 3'($urandom_range(0, 7));
         reg_wdata    = $urandom;
         if (reg_wr && reg_addr == 3'd0) reg_wdata[0] = ($urandom_range(0, 7) != 0);
         step();
      end
      idle(3'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule